// File: doc/BRIEF.md
# Per-Master Masked Address Decoder with Local Error Responder

This block sits on one master port of a multi-layer bus switch. It compares the master's AHB-Lite address against a base and mask pair for every slave port and drives a one-hot slave-select vector for the address phase. A per-master permission vector removes the slaves that this master may not reach. When a real transfer goes to a forbidden slave or to unmapped space, and the matching error option is enabled, the block answers the transfer itself with a two-cycle AHB-Lite ERROR response.

A slave range is matched when the address bits kept by the mask equal the same bits of the base. Mask bits at 0 are don't-care. For example, base 0x4000_0000 with mask 0xE000_0000 claims 0x4000_0000 to 0x5FFF_FFFF. If ranges overlap, the lowest slave index wins. The permission vector is applied after that choice, so a forbidden winner hides a permitted slave that overlaps it. The response generator is a three-state machine. `RSP_OKAY` drives ready high with OKAY. `RSP_STALL` drives ready low with ERROR. `RSP_FLAG` drives ready high with ERROR. The transitions are: OKAY to STALL on an error launch; STALL to FLAG always; FLAG to STALL on a new error launch, otherwise FLAG to OKAY. An error launch is a clock edge with `bus_ready` high, `port_sel` high, a NONSEQ or SEQ transfer, and an address that calls for an error.

Top module: `mst_addr_decoder`

## Requirements
- R1: Slave s is hit when (addr AND mask[s]) equals (base[s] AND mask[s]). With base 0x1000_0000 and mask 0xF000_0000 the range is 0x1000_0000 to 0x1FFF_FFFF. With base 0x4000_0000 and mask 0xE000_0000 the range is 0x4000_0000 to 0x5FFF_FFFF. Addresses just outside each range do not select that slave.
- R2: When several ranges are hit, only the lowest-index slave is selected, so `slv_pick` is always one-hot or zero.
- R3: While `port_sel` is 0, `slv_pick` is all zero and no error is launched.
- R4: A slave whose `ACC_MASK` bit is 0 is never selected, even when its range is hit.
- R5: A NONSEQ (2'b10) or SEQ (2'b11) transfer to a forbidden winning slave whose `ERR_MASK` bit is 1 is answered in the two cycles after the sampling edge. The first cycle has `loc_ready`=0 and `loc_resp`=1 (ERROR). The second has `loc_ready`=1 and `loc_resp`=1. After that the outputs return to `loc_ready`=1 and `loc_resp`=0 (OKAY).
- R6: With `ERR_NONE`=1, a NONSEQ or SEQ transfer whose address hits no range gets the same two-cycle ERROR response as in R5.
- R7: A forbidden access whose `ERR_MASK` bit is 0, or an unmapped access with `ERR_NONE`=0, completes with OKAY and no wait state.
- R8: An IDLE (2'b00) or BUSY (2'b01) transfer completes with OKAY and no wait state, whatever its address.
- R9: A transfer is only sampled on an edge where `bus_ready` is 1. An erroneous transfer present only while `bus_ready` is 0 causes no error.
- R10: `rst_n` low forces `loc_ready`=1 and `loc_resp`=0 at once, without waiting for a clock edge. Both values hold after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sel | input | 1 | Master port select |
| trans_in | input | 2 | Transfer type (00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ) |
| addr_in | input | AW | Master address |
| bus_ready | input | 1 | Ready level on the master's local bus |
| slv_base | input | NS*AW | Base addresses, slave s at bits [s*AW +: AW] |
| slv_mask | input | NS*AW | Address masks, same packing as slv_base |
| slv_pick | output | NS | One-hot select of the addressed, permitted slave |
| loc_ready | output | 1 | Locally generated ready |
| loc_resp | output | 1 | Locally generated response (0 OKAY, 1 ERROR) |

## Verification
The checker tests the following on every cycle: the select stays one-hot or zero, it is empty while the port is unselected, and it never names a forbidden slave. A low ready is always paired with ERROR and is always followed by the ERROR-with-ready cycle. An idle-type transfer sampled while ready is high leads to a plain OKAY. Only the bench scenarios can show the rest: the exact range edges of the mask examples, which slave wins an overlap, how each error option changes the response, that a transfer is not sampled while ready is low, and that reset acts without a clock edge.

// File: rtl/adec_pkg.sv
package adec_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'd0,
        RSP_STALL = 2'd1,
        RSP_FLAG  = 2'd2
    } rsp_state_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/adec_range_cmp.sv
module adec_range_cmp #(
    parameter int AW = 32,
    parameter int NS = 4
) (
    input  logic [AW-1:0]    addr,
    input  logic [NS*AW-1:0] base_flat,
    input  logic [NS*AW-1:0] mask_flat,
    output logic [NS-1:0]    hit
);
    for (genvar s = 0; s < NS; s++) begin : g_cmp
        logic [AW-1:0] b, m;
        assign b      = base_flat[s*AW +: AW];
        assign m      = mask_flat[s*AW +: AW];
        assign hit[s] = ((addr & m) == (b & m));
    end
endmodule

// File: rtl/adec_first_hit.sv
module adec_first_hit #(
    parameter int NS = 4
) (
    input  logic [NS-1:0] req,
    output logic [NS-1:0] first,
    output logic          found
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        first = '0;
        for (int i = 0; i < NS; i++) begin
            if (req[i] && !taken) begin
                first[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        found = taken;
    end
endmodule

// File: rtl/adec_err_fsm.sv
module adec_err_fsm
    import adec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic ready_o,
    output logic resp_o
);
    rsp_state_e cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (cur)
            RSP_OKAY:  nxt = launch ? RSP_STALL : RSP_OKAY;
            RSP_STALL: nxt = RSP_FLAG;
            RSP_FLAG:  nxt = launch ? RSP_STALL : RSP_OKAY;
            default:   nxt = RSP_OKAY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= RSP_OKAY;
        else        cur <= nxt;
    end

    always_comb begin
        ready_o = 1'b1;
        resp_o  = 1'b0;
        unique case (cur)
            RSP_OKAY:  begin ready_o = 1'b1; resp_o = 1'b0; end
            RSP_STALL: begin ready_o = 1'b0; resp_o = 1'b1; end
            RSP_FLAG:  begin ready_o = 1'b1; resp_o = 1'b1; end
            default:   begin ready_o = 1'b1; resp_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mst_addr_decoder.sv
module mst_addr_decoder
    import adec_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          NS       = 4,
    parameter logic [NS-1:0] ACC_MASK = '1,
    parameter logic [NS-1:0] ERR_MASK = ~ACC_MASK,
    parameter bit          ERR_NONE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_sel,
    input  logic [1:0]       trans_in,
    input  logic [AW-1:0]    addr_in,
    input  logic             bus_ready,
    input  logic [NS*AW-1:0] slv_base,
    input  logic [NS*AW-1:0] slv_mask,
    output logic [NS-1:0]    slv_pick,
    output logic             loc_ready,
    output logic             loc_resp
);
    logic [NS-1:0] hit_raw, winner;
    logic          any_hit, real_xfer, forbid_err, none_err, launch;

    adec_range_cmp #(.AW(AW), .NS(NS)) u_cmp (
        .addr      (addr_in),
        .base_flat (slv_base),
        .mask_flat (slv_mask),
        .hit       (hit_raw)
    );

    adec_first_hit #(.NS(NS)) u_first (
        .req   (hit_raw),
        .first (winner),
        .found (any_hit)
    );

    assign slv_pick   = port_sel ? (winner & ACC_MASK) : '0;
    assign real_xfer  = (trans_in == TR_NONSEQ) || (trans_in == TR_SEQ);
    assign forbid_err = |(winner & ~ACC_MASK & ERR_MASK);
    assign none_err   = !any_hit && ERR_NONE;
    assign launch     = bus_ready && port_sel && real_xfer && (forbid_err || none_err);

    adec_err_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .ready_o (loc_ready),
        .resp_o  (loc_resp)
    );
endmodule

// File: rtl/adec_checker.sv
module adec_checker #(
    parameter int            NS       = 4,
    parameter logic [NS-1:0] ACC_MASK = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_sel,
    input logic [1:0]    trans_in,
    input logic          bus_ready,
    input logic [NS-1:0] slv_pick,
    input logic          loc_ready,
    input logic          loc_resp
);
    a_r2_onehot_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_pick));

    a_r3_unselected_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |-> (slv_pick == '0));

    a_r4_forbidden_never: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_pick & ~ACC_MASK) == '0);

    a_r5_stall_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_ready |-> loc_resp);

    a_r5_stall_then_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_ready |=> (loc_ready && loc_resp));

    a_r8_idle_is_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ready && bus_ready && port_sel && !trans_in[1]) |=> (loc_ready && !loc_resp));
endmodule

bind mst_addr_decoder adec_checker #(.NS(NS), .ACC_MASK(ACC_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .trans_in  (trans_in),
    .bus_ready (bus_ready),
    .slv_pick  (slv_pick),
    .loc_ready (loc_ready),
    .loc_resp  (loc_resp)
);

// File: tb/sim_mst_addr_decoder.sv
module sim_mst_addr_decoder;
    localparam int AW = 32;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_sel = 1'b0;
    logic [1:0] trans_in = 2'b00;
    logic [AW-1:0] addr_in = '0;
    logic bus_ready = 1'b1;
    logic [NS*AW-1:0] slv_base, slv_mask;
    logic [NS-1:0] pick0, pick1;
    logic rdy0, rsp0, rdy1, rsp1;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // u0: slave 2 forbidden with error, unmapped space errors
    mst_addr_decoder #(.AW(AW), .NS(NS), .ACC_MASK(4'b1011), .ERR_NONE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .trans_in(trans_in),
        .addr_in(addr_in), .bus_ready(bus_ready), .slv_base(slv_base),
        .slv_mask(slv_mask), .slv_pick(pick0), .loc_ready(rdy0), .loc_resp(rsp0));

    // u1: slave 1 forbidden silently, unmapped space silent
    mst_addr_decoder #(.AW(AW), .NS(NS), .ACC_MASK(4'b1101), .ERR_MASK(4'b0000),
                       .ERR_NONE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .trans_in(trans_in),
        .addr_in(addr_in), .bus_ready(bus_ready), .slv_base(slv_base),
        .slv_mask(slv_mask), .slv_pick(pick1), .loc_ready(rdy1), .loc_resp(rsp1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] t, input logic [31:0] a);
        @(negedge clk);
        port_sel = s; trans_in = t; addr_in = a;
        #0.5;
    endtask

    task automatic go_idle();
        @(negedge clk);
        port_sel = 1'b0; trans_in = 2'b00; bus_ready = 1'b1;
    endtask

    task automatic t_reset();
        #1;
        chk("R10 reset ready", {31'd0, rdy0}, 32'd1);
        chk("R10 reset resp", {31'd0, rsp0}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {30'd0, rdy0, rsp0}, 32'd2);
    endtask

    task automatic t_ranges();
        drive(1, 2'b00, 32'h1000_0000); chk("R1 s0 low", pick0, 32'h1);
        drive(1, 2'b00, 32'h1FFF_FFFF); chk("R1 s0 high", pick0, 32'h1);
        drive(1, 2'b00, 32'h0FFF_FFFF); chk("R1 below s0", pick0, 32'h0);
        drive(1, 2'b00, 32'h4000_0000); chk("R1 s1 low", pick0, 32'h2);
        drive(1, 2'b00, 32'h5FFF_FFFF); chk("R1 s1 high", pick0, 32'h2);
        drive(1, 2'b00, 32'h6000_0000); chk("R1 above s1", pick0, 32'h0);
        drive(1, 2'b00, 32'h3FFF_FFFF); chk("R1 below s1", pick0, 32'h0);
    endtask

    task automatic t_overlap();
        // s0 and s3 both claim 0x18xx_xxxx
        drive(1, 2'b10, 32'h1800_0040); chk("R2 overlap lowest", pick0, 32'h1);
        go_idle();
    endtask

    task automatic t_unselected();
        drive(0, 2'b10, 32'h4000_0000); chk("R3 unselected pick", pick0, 32'h0);
        @(negedge clk);
        chk("R3 unselected no error", {30'd0, rdy0, rsp0}, 32'd2);
        go_idle();
    endtask

    task automatic t_forbid_select();
        drive(1, 2'b00, 32'h8000_0000); chk("R4 u0 forbidden slave2", pick0, 32'h0);
        drive(1, 2'b00, 32'h4000_0100); chk("R4 u1 forbidden slave1", pick1, 32'h0);
        chk("R4 u0 permitted slave1", pick0, 32'h2);
    endtask

    task automatic err_seq(input string tag, input logic [1:0] t, input logic [31:0] a);
        drive(1, t, a);
        @(negedge clk);
        port_sel = 1'b0; trans_in = 2'b00;
        chk({tag, " first cycle"}, {30'd0, rdy0, rsp0}, 32'd1);
        @(negedge clk);
        chk({tag, " second cycle"}, {30'd0, rdy0, rsp0}, 32'd3);
        @(negedge clk);
        chk({tag, " back to okay"}, {30'd0, rdy0, rsp0}, 32'd2);
    endtask

    task automatic t_forbid_err();
        err_seq("R5 nonseq forbidden", 2'b10, 32'h8000_0000);
        err_seq("R5 seq forbidden", 2'b11, 32'h8123_4560);
    endtask

    task automatic t_unmapped_err();
        err_seq("R6 unmapped", 2'b10, 32'h2000_0000);
    endtask

    task automatic t_disabled();
        drive(1, 2'b10, 32'h4000_0000);
        @(negedge clk); port_sel = 1'b0; trans_in = 2'b00;
        chk("R7 u1 forbidden okay", {30'd0, rdy1, rsp1}, 32'd2);
        drive(1, 2'b10, 32'h2000_0000);
        @(negedge clk); port_sel = 1'b0; trans_in = 2'b00;
        chk("R7 u1 unmapped okay", {30'd0, rdy1, rsp1}, 32'd2);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_idle_busy();
        drive(1, 2'b00, 32'h2000_0000);
        @(negedge clk);
        chk("R8 idle unmapped okay", {30'd0, rdy0, rsp0}, 32'd2);
        drive(1, 2'b01, 32'h8000_0000);
        @(negedge clk);
        chk("R8 busy forbidden okay", {30'd0, rdy0, rsp0}, 32'd2);
        go_idle();
    endtask

    task automatic t_ready_low();
        @(negedge clk);
        bus_ready = 1'b0; port_sel = 1'b1; trans_in = 2'b10; addr_in = 32'h2000_0000;
        @(negedge clk);
        port_sel = 1'b0; trans_in = 2'b00; bus_ready = 1'b1;
        chk("R9 not sampled", {30'd0, rdy0, rsp0}, 32'd2);
        @(negedge clk);
        chk("R9 still okay", {30'd0, rdy0, rsp0}, 32'd2);
    endtask

    task automatic t_async_reset();
        drive(1, 2'b10, 32'h2000_0000);
        @(negedge clk);
        port_sel = 1'b0; trans_in = 2'b00;
        chk("R10 error started", {30'd0, rdy0, rsp0}, 32'd1);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R10 async clear", {30'd0, rdy0, rsp0}, 32'd2);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10 okay after release", {30'd0, rdy0, rsp0}, 32'd2);
    endtask

    initial begin
        slv_base = {32'h1800_0000, 32'h8000_0000, 32'h4000_0000, 32'h1000_0000};
        slv_mask = {32'hF800_0000, 32'hF000_0000, 32'hE000_0000, 32'hF000_0000};
        t_reset();
        t_ranges();
        t_overlap();
        t_unselected();
        t_forbid_select();
        t_forbid_err();
        t_unmapped_err();
        t_disabled();
        t_idle_busy();
        t_ready_low();
        t_async_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule